// File: doc/BRIEF.md
# Command-Completion Register Block

This block is a stand-in for the register interface of a platform environment controller link. Software sees a file of 32-bit words and accesses it through separate read and write strobes and a byte offset. A fire bit starts a command. The command finishes in the same clock edge that accepts it. When it finishes, a fixed success completion code is placed in the first word of the outgoing and the incoming data buffers. A command-done flag is then raised in a status word, masked by an enable word. A level interrupt tells software when that flag is set.

The block has no wire protocol, framing or checksum logic. It models only the register file, the status handshake and the interrupt line. Firmware and driver tests can therefore run against it without a real target on the wire. Software must clear the status before it can start a second command. Any fire that arrives while status is still pending is dropped without a trace.

Top module: `cmd_done_regblk`

## Requirements
- R1: After reset every word reads zero and `irqOut` is low.
- R2: A write to any word-aligned offset below 0x40 stores the full 32-bit value, except at 0x08 and 0x1C. A later read of that offset returns the value, with `rdData` valid in the cycle after the read strobe.
- R3: The command word at 0x08 always reads zero. A write there with bit 0 clear changes no word and leaves `irqOut` unchanged.
- R4: Writing 1 to bit 0 of 0x08 while the status word at 0x1C is zero is an accepted fire. It loads 0x40 into both 0x20 (outgoing buffer) and 0x30 (incoming buffer).
- R5: An accepted fire replaces the status word with (enable word at 0x18) AND 0x1. Bit 0 of status is command-done. No other status bit can be set.
- R6: If bit 0 of the enable word is clear, an accepted fire leaves status at zero and `irqOut` low. The buffer words are still loaded.
- R7: A fire while status is nonzero is dropped. The buffer words, the status word and `irqOut` all stay unchanged.
- R8: A write to 0x1C clears each status bit where the data has a 1 and leaves the other bits as they were. `irqOut` falls on the next edge only when the status becomes zero.
- R9: A read at offset 0x40 or above, or at an offset that is not word-aligned, returns zero. A write to such an offset changes nothing.
- R10: When a read and a write hit the same word in one cycle, the read returns the value from before the write.
- R11: `irqOut` is registered. It rises on the edge that accepts a fire with command-done enabled, and it stays high until status is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| irqOut | output | 1 | Level interrupt for command-done |

## Verification
A read and a write can land in the same cycle, so a single edge can both sample a word and update it. The bench drives both strobes at one offset in one cycle with new data. It requires the returned value to be the old contents, and a second read to show the new contents. A second overlap is a fire that arrives while status is still pending. The bench refills the buffer words with marker values, fires again, and checks that the markers, the status word and the interrupt line all survive.

// File: rtl/cmd_done_pkg.sv
package cmd_done_pkg;
  // Word indices whose position the completion behaviour depends on.
  localparam int CMD_IDX = 2;   // offset 0x08
  localparam int ENA_IDX = 6;   // offset 0x18
  localparam int STS_IDX = 7;   // offset 0x1C
  localparam int TXB_IDX = 8;   // offset 0x20
  localparam int RXB_IDX = 12;  // offset 0x30

  typedef struct packed {
    logic wrStore;  // plain store into the addressed word
    logic stsClr;   // write-one-to-clear on status
    logic fire;     // accepted fire
    logic rdHit;    // read of an implemented, aligned word
  } regStrobes_t;
endpackage

// File: rtl/cmd_done_ctrl.sv
module cmd_done_ctrl
  import cmd_done_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fireBit,
  input  logic              stsPend,
  output regStrobes_t       stb,
  output logic [IDX_W-1:0]  idx
);
  localparam int LIMIT = NUM_REGS * 4;

  logic inRange;
  logic aligned;
  logic hit;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    inRange = (int'(addr) < LIMIT);
    hit     = aligned && inRange;
    idx     = addr[IDX_W+1:2];

    stb.rdHit   = rdEn && hit;
    stb.stsClr  = wrEn && hit && (idx == IDX_W'(STS_IDX));
    stb.fire    = wrEn && hit && (idx == IDX_W'(CMD_IDX)) && fireBit && !stsPend;
    stb.wrStore = wrEn && hit && (idx != IDX_W'(STS_IDX)) && (idx != IDX_W'(CMD_IDX));
  end
endmodule

// File: rtl/cmd_done_datapath.sv
module cmd_done_datapath
  import cmd_done_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          NUM_REGS  = 16,
  parameter logic [31:0] DONE_CODE = 32'h40,
  localparam int         IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       stb,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              stsPend,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] DONE_BIT = DATA_W'(1);

  logic [NUM_REGS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0] stsAfterClr;
  logic [DATA_W-1:0] stsOnFire;
  logic [DATA_W-1:0] rdQ;
  logic              irqQ;

  assign stsAfterClr = words[STS_IDX] & ~wrData;
  assign stsOnFire   = words[ENA_IDX] & DONE_BIT;

  for (genvar w = 0; w < NUM_REGS; w++) begin : g_word
    if (w == CMD_IDX) begin : g_cmd
      assign words[w] = '0;
    end else if (w == STS_IDX) begin : g_sts
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           q <= '0;
        else if (stb.fire)   q <= stsOnFire;
        else if (stb.stsClr) q <= stsAfterClr;
      end
      assign words[w] = q;
    end else if (w == TXB_IDX || w == RXB_IDX) begin : g_buf
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                   q <= '0;
        else if (stb.fire)                           q <= DONE_CODE[DATA_W-1:0];
        else if (stb.wrStore && idx == IDX_W'(w))    q <= wrData;
      end
      assign words[w] = q;
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                q <= '0;
        else if (stb.wrStore && idx == IDX_W'(w)) q <= wrData;
      end
      assign words[w] = q;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  irqQ <= 1'b0;
    else if (stb.fire)                          irqQ <= |stsOnFire;
    else if (stb.stsClr && stsAfterClr == '0)   irqQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdQ <= '0;
    else if (rdEn) rdQ <= stb.rdHit ? words[idx] : '0;
  end

  assign rdData  = rdQ;
  assign irqOut  = irqQ;
  assign stsPend = |words[STS_IDX];
endmodule

// File: rtl/cmd_done_regblk.sv
module cmd_done_regblk
  import cmd_done_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter int          NUM_REGS  = 16,
  parameter logic [31:0] DONE_CODE = 32'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int IDX_W = $clog2(NUM_REGS);

  regStrobes_t      stb;
  logic [IDX_W-1:0] idx;
  logic             stsPend;

  cmd_done_ctrl #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) ctrl_i (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .fireBit(wrData[0]),
    .stsPend(stsPend), .stb(stb), .idx(idx)
  );

  cmd_done_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .DONE_CODE(DONE_CODE)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdEn(rdEn), .idx(idx), .wrData(wrData),
    .rdData(rdData), .stsPend(stsPend), .irqOut(irqOut)
  );
endmodule

// File: rtl/cmd_done_regblk_chk.sv
module cmd_done_regblk_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut,
  input logic              stsPend
);
  localparam int LIMIT = NUM_REGS * 4;

  logic cmdFire, stsWrite, cmdRead, badRead;
  assign cmdFire  = wrEn && addr == ADDR_W'(8'h08) && wrData[0];
  assign stsWrite = wrEn && addr == ADDR_W'(8'h1C);
  assign cmdRead  = rdEn && addr == ADDR_W'(8'h08);
  assign badRead  = rdEn && ((int'(addr) >= LIMIT) || addr[1:0] != 2'b00);

  p_cmd_reads_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdRead |=> rdData == '0);

  p_reject_keeps_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdFire && stsPend) |=> irqOut == $past(irqOut));

  p_irq_fall_on_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(stsWrite));

  p_bad_read_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    badRead |=> rdData == '0);

  p_irq_rise_on_fire_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(cmdFire));

  p_irq_pending_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> stsPend);
endmodule

bind cmd_done_regblk cmd_done_regblk_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .stsPend(stsPend)
);

// File: tb/cmd_done_regblk_tb_top.sv
module cmd_done_regblk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_done_regblk dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rdReg(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    expectReg("R1", 8'h00, 32'h0);
    expectReg("R1", 8'h18, 32'h0);
    expectReg("R1", 8'h1C, 32'h0);
    expectReg("R1", 8'h20, 32'h0);
    expectReg("R1", 8'h30, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_plain();
    wrReg(8'h00, 32'hDEADBEEF);
    wrReg(8'h3C, 32'h12345678);
    wrReg(8'h24, 32'hA5A5_0F0F);
    expectReg("R2", 8'h00, 32'hDEADBEEF);
    expectReg("R2", 8'h3C, 32'h12345678);
    expectReg("R2", 8'h24, 32'hA5A5_0F0F);
  endtask

  task automatic t_cmd_noop();
    wrReg(8'h20, 32'h0000_0011);
    wrReg(8'h08, 32'hFFFF_FFFE);
    expectReg("R3 cmd reads zero", 8'h08, 32'h0);
    expectReg("R3 buffer untouched", 8'h20, 32'h11);
    expectReg("R3 status untouched", 8'h1C, 32'h0);
    check("R3 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_fire_masked();
    wrReg(8'h18, 32'hFFFF_FFFE);
    wrReg(8'h30, 32'h0000_0022);
    wrReg(8'h08, 32'h1);
    check("R6 irq stays low", {31'b0, irqOut}, 32'h0);
    expectReg("R4 tx code", 8'h20, 32'h40);
    expectReg("R4 rx code", 8'h30, 32'h40);
    expectReg("R6 status zero", 8'h1C, 32'h0);
  endtask

  task automatic t_fire_irq();
    wrReg(8'h18, 32'hFFFF_FFFF);
    wrReg(8'h20, 32'h0000_00AA);
    wrReg(8'h30, 32'h0000_00BB);
    wrReg(8'h08, 32'h1);
    check("R11 irq rises after fire", {31'b0, irqOut}, 32'h1);
    expectReg("R5 status bit0 only", 8'h1C, 32'h1);
    expectReg("R4 tx code", 8'h20, 32'h40);
    expectReg("R4 rx code", 8'h30, 32'h40);
    repeat (5) @(negedge clk);
    check("R11 irq held", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic t_reject();
    wrReg(8'h20, 32'h0000_0055);
    wrReg(8'h30, 32'h0000_0066);
    wrReg(8'h18, 32'h0);
    wrReg(8'h08, 32'h1);
    expectReg("R7 tx kept", 8'h20, 32'h55);
    expectReg("R7 rx kept", 8'h30, 32'h66);
    expectReg("R7 status kept", 8'h1C, 32'h1);
    check("R7 irq kept", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic t_clear();
    wrReg(8'h1C, 32'hFFFF_FFFE);
    expectReg("R8 zero bits leave status", 8'h1C, 32'h1);
    check("R8 irq still high", {31'b0, irqOut}, 32'h1);
    wrReg(8'h1C, 32'h1);
    check("R8 irq falls", {31'b0, irqOut}, 32'h0);
    expectReg("R8 status cleared", 8'h1C, 32'h0);
    wrReg(8'h18, 32'h1);
    wrReg(8'h08, 32'h1);
    check("R5 refire after clear", {31'b0, irqOut}, 32'h1);
    wrReg(8'h1C, 32'h1);
    check("R8 irq falls again", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_out_of_range();
    wrReg(8'h40, 32'hCAFE_0001);
    wrReg(8'h01, 32'hCAFE_0002);
    wrReg(8'h1E, 32'hFFFF_FFFF);
    expectReg("R9 read beyond range", 8'h40, 32'h0);
    expectReg("R9 read beyond range high", 8'hFC, 32'h0);
    expectReg("R9 misaligned read", 8'h01, 32'h0);
    expectReg("R9 word0 unchanged", 8'h00, 32'hDEADBEEF);
  endtask

  task automatic t_same_cycle();
    wrReg(8'h04, 32'h1111_1111);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 8'h04; wrData = 32'h2222_2222;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R10 read sees old value", rdData, 32'h1111_1111);
    expectReg("R10 new value stored", 8'h04, 32'h2222_2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_plain();
    t_cmd_noop();
    t_fire_masked();
    t_fire_irq();
    t_reject();
    t_clear();
    t_out_of_range();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule